// File: doc/BRIEF.md
# Slow-Peripheral Cycle Stretcher

This block makes the processor clock for a 2 MHz CPU that shares its bus with peripherals that run at only 1 MHz. It runs entirely on a 16 MHz master clock. A free-running divider produces in-phase 8, 4, 2 and 1 MHz phases, all low at reset and all falling together once every 16 master cycles. Normally the CPU clock simply follows the 2 MHz phase.

The address decoder raises `slow_sel_i` when the current access targets a slow device. The block samples that select once per CPU cycle, in the last master cycle of the CPU clock's low phase. A sampled request latches a "stretch" flip-flop, and the CPU clock is then held high. A second flip-flop arms when the 1 MHz phase rises during the stretch. The stretch is released at the next master-cycle boundary where the 1 MHz and 2 MHz phases fall together. A request taken while the 1 MHz phase is low gives a high time of 3 half-cycles of the 2 MHz clock. A request taken while it is high gives 5 half-cycles. In the 5-half-cycle case the slow device sees two 1 MHz high phases, and `dbl_acc_o` flags this double access. The CPU clock is a flip-flop output, so its edges are glitch-free and land on master-clock boundaries.

Top module: `cyc_stretch`

## Requirements
- R1: While `rst_ni` is low, every output is low. This holds immediately on assertion of reset, including in the middle of a stretch.
- R2: After reset is released, `ph8_o`, `ph4_o`, `ph2_o` and `per_clk_o` form a binary count that starts at 0, with `ph8_o` as bit 0 and `per_clk_o` as bit 3. The count advances by one on each master clock edge. As a result, all four phases fall together every 16 cycles.
- R3: With no accepted request, `cpu_clk_o` equals `ph2_o` in every cycle.
- R4: `slow_sel_i` is only looked at in the master cycle where the count is 3 or 11, which is the last cycle before `ph2_o` rises. At any other count it has no effect on the outputs.
- R5: A request accepted at count 3 (1 MHz phase low) holds `cpu_clk_o` high for 12 master cycles, covering counts 4 to 15. The clock falls together with `per_clk_o`.
- R6: A request accepted at count 11 (1 MHz phase high) holds `cpu_clk_o` high for 20 master cycles, covering counts 12 through the following 15. The clock falls together with `per_clk_o`.
- R7: `stretch_o` is high for exactly the stretched high time of `cpu_clk_o` and is low otherwise.
- R8: A select presented at a sample point while a stretch is active is ignored. It neither lengthens the stretch nor changes `dbl_acc_o`, and the CPU cycle after the release has the normal 4-cycle high time.
- R9: `dbl_acc_o` is high for the whole of a 20-cycle stretch and stays low during a 12-cycle stretch.
- R10: Every falling edge of `cpu_clk_o` coincides with a falling edge of `ph2_o`. The only high times are 4, 12 or 20 master cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | 16 MHz master clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| slow_sel_i | input | 1 | Slow-device select from the address decoder |
| cpu_clk_o | output | 1 | Stretched CPU clock |
| per_clk_o | output | 1 | 1 MHz peripheral clock phase |
| ph2_o | output | 1 | Unstretched 2 MHz phase |
| ph4_o | output | 1 | 4 MHz phase |
| ph8_o | output | 1 | 8 MHz phase |
| stretch_o | output | 1 | Stretch in progress |
| dbl_acc_o | output | 1 | Current stretch gives the slow device a double access |

## Verification
Two pairs of events can land in the same master cycle.

The first pair is the stretch release and the fall of the 1 MHz phase. The bench checks that the stretched CPU clock drops in the very cycle where `per_clk_o` and `ph2_o` drop.

The second pair is the sample point at count 11 and an active short stretch. The bench starts a stretch at count 3 and then pulses the select exactly at count 11. It then judges that the stretch still ends at count 0, that `dbl_acc_o` stays low, and that the next CPU high time is the normal 4 cycles. Table vectors also place the select at non-sample counts to show that it is ignored.

// File: rtl/cstr_pkg.sv
package cstr_pkg;
  // single-cycle strobes decoded from the phase count
  typedef struct packed {
    logic smp;  // last cycle of 2 MHz low phase: sample select
    logic arm;  // 1 MHz phase about to rise
    logic rel;  // all phases about to fall together
  } tick_t;
endpackage

// File: rtl/cstr_phase.sv
module cstr_phase
  import cstr_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] cnt_nxt_o,
  output tick_t            tick_o
);
  localparam int FB = CNT_W - 2;  // 2 MHz bit
  localparam int SB = CNT_W - 1;  // 1 MHz bit

  logic [CNT_W-1:0] cnt_q;

  assign cnt_nxt_o = cnt_q + 1'b1;
  assign cnt_o     = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_nxt_o;
  end

  always_comb begin
    tick_o.smp = (cnt_q[FB:0] == {1'b0, {FB{1'b1}}});
    tick_o.arm = (cnt_q == {1'b0, {SB{1'b1}}});
    tick_o.rel = &cnt_q;
  end

  for (genvar i = 0; i < SB; i++) begin : g_align
    // R2
    phase_align_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(cnt_q[SB]) |-> $fell(cnt_q[i]));
  end
endmodule

// File: rtl/cstr_ctl.sv
module cstr_ctl
  import cstr_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  sel_i,
  input  logic  slow_i,
  input  tick_t tick_i,
  output logic  hold_nxt_o,
  output logic  stretch_o,
  output logic  dbl_o
);
  logic mem_q, arm_q, dbl_q;
  logic mem_d, arm_d, dbl_d;
  logic start, clr;

  assign start = tick_i.smp & sel_i & ~mem_q;
  assign clr   = tick_i.rel & arm_q;

  always_comb begin
    mem_d = start | (mem_q & ~clr);
    arm_d = (arm_q & ~clr) | (tick_i.arm & mem_q);
    dbl_d = start ? slow_i : (dbl_q & ~clr);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mem_q <= 1'b0;
      arm_q <= 1'b0;
      dbl_q <= 1'b0;
    end else begin
      mem_q <= mem_d;
      arm_q <= arm_d;
      dbl_q <= dbl_d;
    end
  end

  assign hold_nxt_o = mem_d;
  assign stretch_o  = mem_q;
  assign dbl_o      = dbl_q;

  // R5
  rel_by_arm_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(mem_q) |-> $past(arm_q) && $past(slow_i));
  // R9
  dbl_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(dbl_q) |-> $rose(mem_q) && $past(slow_i));
  // R8
  busy_ignore_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_q && tick_i.smp |=> mem_q && $stable(dbl_q));
endmodule

// File: rtl/cstr_out.sv
module cstr_out #(
  parameter int HALF = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic fast_i,
  input  logic fast_nxt_i,
  input  logic hold_nxt_i,
  output logic cpu_clk_o
);
  localparam int MAXH = 5 * HALF;
  localparam int HW   = $clog2(MAXH + 2);

  logic cpu_q;
  logic [HW-1:0] hi_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cpu_q <= 1'b0;
    else         cpu_q <= fast_nxt_i | hold_nxt_i;
  end

  assign cpu_clk_o = cpu_q;

  // high-time monitor for the checker
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    hi_q <= '0;
    else if (cpu_q) hi_q <= (hi_q == HW'(MAXH + 1)) ? hi_q : hi_q + 1'b1;
    else            hi_q <= '0;
  end

  // R10
  cpu_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cpu_q) |-> $fell(fast_i));
  // R10
  cpu_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cpu_q) |-> (hi_q == HW'(HALF)) || (hi_q == HW'(3 * HALF)) || (hi_q == HW'(MAXH)));
endmodule

// File: rtl/cyc_stretch.sv
module cyc_stretch
  import cstr_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic slow_sel_i,
  output logic cpu_clk_o,
  output logic per_clk_o,
  output logic ph2_o,
  output logic ph4_o,
  output logic ph8_o,
  output logic stretch_o,
  output logic dbl_acc_o
);
  localparam int FB   = CNT_W - 2;
  localparam int SB   = CNT_W - 1;
  localparam int HALF = 2 ** FB;

  logic [CNT_W-1:0] cnt, cnt_nxt;
  tick_t            tick;
  logic             hold_nxt;

  cstr_phase #(.CNT_W(CNT_W)) u_phase (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .cnt_o    (cnt),
    .cnt_nxt_o(cnt_nxt),
    .tick_o   (tick)
  );

  cstr_ctl u_ctl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .sel_i     (slow_sel_i),
    .slow_i    (cnt[SB]),
    .tick_i    (tick),
    .hold_nxt_o(hold_nxt),
    .stretch_o (stretch_o),
    .dbl_o     (dbl_acc_o)
  );

  cstr_out #(.HALF(HALF)) u_out (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .fast_i    (cnt[FB]),
    .fast_nxt_i(cnt_nxt[FB]),
    .hold_nxt_i(hold_nxt),
    .cpu_clk_o (cpu_clk_o)
  );

  assign per_clk_o = cnt[SB];
  assign ph2_o     = cnt[FB];
  assign ph4_o     = cnt[FB-1];
  assign ph8_o     = cnt[FB-2];

  // R7
  stretch_cpu_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(stretch_o) |-> $fell(cpu_clk_o) && $fell(per_clk_o));
endmodule

// File: tb/sim_cyc_stretch.sv
module sim_cyc_stretch;
  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic slow_sel_i = 1'b0;
  logic cpu_clk_o, per_clk_o, ph2_o, ph4_o, ph8_o, stretch_o, dbl_acc_o;

  int total = 0;
  int fails = 0;
  int ph = 0;

  localparam int NV = 5;
  localparam int VEC_P[NV]   = '{3, 11, 0, 9, 7};
  localparam int VEC_LEN[NV] = '{12, 20, 4, 4, 4};
  localparam int VEC_DBL[NV] = '{0, 1, 0, 0, 0};

  always #2 clk_i = ~clk_i;

  cyc_stretch u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .slow_sel_i(slow_sel_i),
    .cpu_clk_o(cpu_clk_o), .per_clk_o(per_clk_o), .ph2_o(ph2_o),
    .ph4_o(ph4_o), .ph8_o(ph8_o), .stretch_o(stretch_o), .dbl_acc_o(dbl_acc_o)
  );

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk_i);
    ph = (ph + 1) % 16;
  endtask

  task automatic goto(input int p);
    while (ph != p) step();
  endtask

  task automatic pulse_at(input int p);
    goto(p);
    slow_sel_i = 1'b1;
    step();
    slow_sel_i = 1'b0;
  endtask

  // length of the next high run of cpu_clk_o and what was seen during it
  task automatic run_len(output int len, output int dbl_any, output int stb_all,
                         output int stb_any, output int end_ph);
    int guard = 0;
    len = 0; dbl_any = 0; stb_all = 1; stb_any = 0;
    while (!cpu_clk_o && guard < 64) begin step(); guard++; end
    while (cpu_clk_o && guard < 128) begin
      len++;
      if (dbl_acc_o) dbl_any = 1;
      if (stretch_o) stb_any = 1; else stb_all = 0;
      step(); guard++;
    end
    end_ph = ph;
  endtask

  initial begin
    #200000;
    fails++; total++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    int len, dbl_any, stb_all, stb_any, end_ph;
    // R1: reset state
    repeat (3) @(negedge clk_i);
    chk({cpu_clk_o, per_clk_o, ph2_o, ph4_o, ph8_o, stretch_o, dbl_acc_o} == 7'b0,
        "R1 reset outputs", int'({cpu_clk_o, per_clk_o, ph2_o, ph4_o, ph8_o, stretch_o, dbl_acc_o}), 0);
    rst_ni = 1'b1;
    ph = 0;

    // R2, R3: free-running phases and unstretched CPU clock
    for (int i = 0; i < 32; i++) begin
      step();
      chk({per_clk_o, ph2_o, ph4_o, ph8_o} == 4'(ph), "R2 phase count",
          int'({per_clk_o, ph2_o, ph4_o, ph8_o}), ph);
      chk(cpu_clk_o == ph2_o, "R3 cpu follows 2 MHz", cpu_clk_o, ph2_o);
    end

    // vector table: R4 R5 R6 R9 R7
    for (int v = 0; v < NV; v++) begin
      pulse_at(VEC_P[v]);
      run_len(len, dbl_any, stb_all, stb_any, end_ph);
      chk(len == VEC_LEN[v], "R4/R5/R6 high length", len, VEC_LEN[v]);
      chk(dbl_any == VEC_DBL[v], "R9 dbl_acc_o", dbl_any, VEC_DBL[v]);
      if (VEC_LEN[v] > 4) begin
        chk(stb_all == 1, "R7 stretch_o during stretch", stb_all, 1);
        chk(end_ph == 0 && !per_clk_o && !stretch_o, "R5/R6 release on 1 MHz fall", end_ph, 0);
      end else begin
        chk(stb_any == 0, "R4 stretch_o stays low", stb_any, 0);
      end
    end

    // R9: dbl high throughout a long stretch
    pulse_at(11);
    begin
      int all = 1;
      for (int i = 0; i < 20; i++) begin
        if (!dbl_acc_o || !cpu_clk_o) all = 0;
        step();
      end
      chk(all == 1, "R9 dbl_acc_o whole stretch", all, 1);
      chk(!cpu_clk_o && !dbl_acc_o && ph == 0, "R6 release after 20", cpu_clk_o, 0);
    end

    // R8: select at count 11 during a short stretch is ignored
    pulse_at(3);
    pulse_at(11);
    chk(dbl_acc_o == 1'b0, "R8 dbl unchanged by busy sample", dbl_acc_o, 0);
    goto(0);
    chk(!cpu_clk_o && !stretch_o, "R8 stretch not extended", cpu_clk_o, 0);
    run_len(len, dbl_any, stb_all, stb_any, end_ph);
    chk(len == 4, "R8 next cycle normal", len, 4);

    // R1: reset in the middle of a stretch
    pulse_at(3);
    step(); step();
    chk(stretch_o == 1'b1, "R7 stretch active before reset", stretch_o, 1);
    rst_ni = 1'b0;
    #1;
    chk({cpu_clk_o, per_clk_o, ph2_o, ph4_o, ph8_o, stretch_o, dbl_acc_o} == 7'b0,
        "R1 reset mid stretch", int'({cpu_clk_o, per_clk_o, ph2_o, ph4_o, ph8_o, stretch_o, dbl_acc_o}), 0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    ph = 0;
    step();
    chk({per_clk_o, ph2_o, ph4_o, ph8_o} == 4'd1 && !cpu_clk_o, "R2 restart from zero",
        int'({per_clk_o, ph2_o, ph4_o, ph8_o}), 1);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule